// File: doc/BRIEF.md
# Collision-Vector Start Controller

This block decides, cycle by cycle, whether a new task may enter a non-linear pipeline whose stages are reused at fixed offsets. The stage-usage pattern is summarised at elaboration time as a collision vector: a bit set for every start-to-start distance, in cycles, that would put two tasks on the same stage in the same cycle. The controller keeps a shifting record of the distances that earlier accepted starts still forbid, and grants a start request only when the current cycle is clear for all of them, so no collision can ever occur.

Besides the grant, it reports the distance in cycles between the start being granted now and the previous accepted start (saturating once that distance can no longer matter), and it keeps running totals of accepted starts and elapsed cycles. Dividing the cycle total by the start total gives the average latency achieved by the requesting logic. A requester that is refused may keep its request raised; it is granted in the first cycle that is permissible.

Top module: `launch_gate`

## Requirements
- R1: While reset is held and in the first cycle after it is released, the forbidden-distance record is empty, `lat_o` equals MAXF+1, `starts_o` and `cycles_o` are zero, and a request in that first cycle is granted.
- R2: `grant_o` is 1 in a cycle exactly when `req_i` is 1 and no accepted start lies i cycles earlier (1 <= i <= MAXF) with bit i-1 of CVEC set; bit i-1 of CVEC stands for distance i. The default CVEC 6'b101100 forbids distances 3, 4 and 6.
- R3: A refused request that is kept raised is granted in the first later cycle in which R2 allows it, and in no cycle before that.
- R4: With the request held high continuously, each start accounts for every earlier start within MAXF cycles, not only the latest one, so the grant pattern follows the greedy schedule built from R2.
- R5: `lat_o` equals the number of cycles since the last accepted start, with 1 meaning the previous cycle, and stays at MAXF+1 once that count exceeds MAXF or when no start has been accepted since reset.
- R6: `starts_o` increases by one in the cycle after each grant and is otherwise unchanged.
- R7: `cycles_o` increases by one on every clock edge out of reset.
- R8: A cycle with `req_i` low produces no grant and leaves `starts_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Request to start a task in this cycle |
| grant_o | output | 1 | Start accepted in this cycle |
| lat_o | output | $clog2(MAXF+2) | Cycles since the previous accepted start, saturating at MAXF+1 |
| starts_o | output | CNT_W | Total accepted starts since reset |
| cycles_o | output | CNT_W | Total cycles since reset |

## Verification
On every cycle the assertions check that a grant never falls at a forbidden distance from the previous start, that a start loads all of its forbidden distances into the record, and that the latency and the two totals step as required. Whether a grant correctly accounts for starts older than the previous one, whether a held request is granted in precisely the first clear cycle, and the values right after reset can only be shown by the bench, whose reference model keeps the list of recent start times and recomputes every output each cycle under greedy, spaced, idle and irregular request patterns.

// File: rtl/launch_gate.sv
module launch_gate #(
  parameter int MAXF = 6,
  parameter logic [MAXF-1:0] CVEC = 6'b101100,
  parameter int CNT_W = 32,
  localparam int LAT_W = $clog2(MAXF + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  output logic             grant_o,
  output logic [LAT_W-1:0] lat_o,
  output logic [CNT_W-1:0] starts_o,
  output logic [CNT_W-1:0] cycles_o
);

  localparam logic [LAT_W-1:0] LAT_SAT = LAT_W'(MAXF + 1);

  logic [MAXF-1:0]  fb_q;
  logic [LAT_W-1:0] lat_q;
  logic [CNT_W-1:0] starts_q, cycles_q;

  assign grant_o  = req_i & ~fb_q[0];
  assign lat_o    = lat_q;
  assign starts_o = starts_q;
  assign cycles_o = cycles_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fb_q     <= '0;
      lat_q    <= LAT_SAT;
      starts_q <= '0;
      cycles_q <= '0;
    end else begin
      fb_q     <= (fb_q >> 1) | (grant_o ? CVEC : '0);
      cycles_q <= cycles_q + CNT_W'(1);
      if (grant_o) begin
        lat_q    <= LAT_W'(1);
        starts_q <= starts_q + CNT_W'(1);
      end else if (lat_q != LAT_SAT) begin
        lat_q    <= lat_q + LAT_W'(1);
      end
    end
  end

  AST_NO_COLLISION: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o && lat_q <= LAT_W'(MAXF)) |-> !CVEC[lat_q - LAT_W'(1)]); // R2

  AST_STATE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |=> ((fb_q & CVEC) == CVEC)); // R4

  AST_LAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q >= LAT_W'(1)) && (lat_q <= LAT_SAT)); // R5

  AST_LAT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |=> (lat_q == LAT_W'(1))); // R5

  AST_START_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |=> (starts_q == $past(starts_q) + CNT_W'(1))); // R6

  AST_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> $stable(starts_q)); // R8

  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cycles_q == $past(cycles_q) + CNT_W'(1))); // R7

endmodule

// File: tb/launch_gate_bench.sv
`timescale 1ns/1ps
module launch_gate_bench;
  localparam int M = 6;
  localparam logic [M-1:0] CV = 6'b101100;
  localparam int LW = $clog2(M + 2);

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic grant;
  logic [LW-1:0] lat;
  logic [31:0] starts, cycles;

  always #2.5 clk = ~clk;

  launch_gate #(.MAXF(M), .CVEC(CV), .CNT_W(32)) u_launch_gate (
    .clk(clk), .rst_n(rst_n), .req_i(req),
    .grant_o(grant), .lat_o(lat), .starts_o(starts), .cycles_o(cycles)
  );

  int checks = 0, fails = 0;
  int now = 0, last = -1, nst = 0;
  int gq[$];
  bit refused_prev = 0;
  string gtag = "";

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle=%0d act=%0d exp=%0d", tag, now, act, exp);
    end
  endtask

  function automatic bit allowed();
    foreach (gq[i]) begin
      int d = now - gq[i];
      if (d >= 1 && d <= M && CV[d-1]) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic step(input bit r);
    bit eg;
    int el;
    string tg;
    @(negedge clk);
    req = r;
    #1;
    eg = r && allowed();
    el = (last < 0 || now - last > M + 1) ? M + 1 : now - last;
    if (now == 0) tg = "R1";
    else if (!r) tg = "R8";
    else if (gtag != "") tg = gtag;
    else if (refused_prev) tg = "R3";
    else tg = "R2";
    chk({tg, " grant"}, grant, eg);
    chk(now == 0 ? "R1 lat" : "R5 lat", lat, el);
    chk(now == 0 ? "R1 starts" : (r ? "R6 starts" : "R8 starts"), starts, nst);
    chk(now == 0 ? "R1 cycles" : "R7 cycles", cycles, now);
    if (eg) begin
      gq.push_back(now);
      last = now;
      nst++;
    end
    refused_prev = r && !eg;
    now++;
    while (gq.size() > 0 && now - gq[0] > M) void'(gq.pop_front());
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    now = 0; last = -1; nst = 0; refused_prev = 0;
    gq.delete();
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 first request after reset, then R4 greedy schedule with request held
    gtag = "R4";
    repeat (40) step(1'b1);
    gtag = "";
    // spaced single requests at every distance, held until granted (R3)
    for (int k = 1; k <= M + 2; k++) begin
      repeat (k - 1) step(1'b0);
      step(1'b1);
      while (refused_prev) step(1'b1);
    end
    // long idle for latency saturation (R5), no grants without request (R8)
    repeat (20) step(1'b0);
    step(1'b1);
    step(1'b1);
    // irregular requests
    for (int i = 0; i < 600; i++) step($urandom_range(0, 3) != 0);
    // reset in mid-run, R1 again with request present
    do_reset();
    step(1'b1);
    for (int i = 0; i < 200; i++) step($urandom_range(0, 1) == 1);
    finish_run();
  end
endmodule